// File: doc/BRIEF.md
# RTC Periodic Rate Generator and Interrupt Flag Unit

This block sits beside the time-keeping counters of a real-time clock. It receives a one-cycle tick at the 32.768 kHz reference rate and runs it through a binary prescaler. A 4-bit rate code picks one tap of that prescaler, which yields a periodic event and a square-wave output. A 3-bit divider-control field can hold the prescaler in reset.

The periodic event is combined with alarm-match and update-done pulses, which arrive from outside as single-cycle inputs. Together they form a three-flag interrupt register with a summary bit. Each flag is latched whether or not it is enabled. The summary bit and the interrupt request follow only the flags whose enable pins are high. Software reads the flag byte with a one-cycle strobe, and the read clears it. An event that lands in the same cycle as the read is kept.

Any divider-control code that does not hold the prescaler runs the same 32.768 kHz chain. Codes that would name a faster reference therefore behave as the 32.768 kHz setting.

Top module: `rtc_rate_irq`

## Requirements
- R1: For rate code r in 1..15, a periodic event occurs once every 2^(r-1) reference ticks (code 1 on every tick, code 15 every 16384 ticks). Code 0 produces no periodic event and never sets the periodic flag.
- R2: While `sqw_en` is high and the rate code is nonzero, `sqw` toggles on each periodic event, so a full square-wave cycle spans 2^r ticks. `sqw` is held low while `sqw_en` is low or the rate code is 0.
- R3: Divider-control codes 3'b110 and 3'b111 hold the prescaler at zero. While either code is applied there are no periodic events, the periodic flag does not set, and `sqw` is held low.
- R4: Leaving a hold code restarts the prescaler from zero. The first periodic event, and so the first `sqw` rise, follows exactly 2^(r-1) ticks after release.
- R5: All divider-control codes other than 3'b110 and 3'b111 (for example 3'b000, 3'b001, 3'b010) give the same periodic rate from the reference tick.
- R6: The flag byte holds the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3..0 read as zero. Each flag sets on its event whatever the state of its enable, and it stays set until read.
- R7: Bit 7 of the flag byte is high when any flag is set together with its enable (`per_irq_en`, `alm_irq_en`, `upd_irq_en`). `irq` always equals bit 7, and it follows an enable change in the same cycle.
- R8: With `flag_rd` high, `flag_rdata` shows the current flags in that cycle, and every flag and the summary bit clear at the next clock edge.
- R9: An event arriving in the same cycle as `flag_rd` is latched after the clear, so its flag reads as set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the 32.768 kHz reference rate |
| div_ctl | input | 3 | Divider control; 3'b110 and 3'b111 hold the prescaler |
| rate_sel | input | RATE_W | Periodic / square-wave rate code, 0 = off |
| per_irq_en | input | 1 | Periodic interrupt enable |
| alm_irq_en | input | 1 | Alarm interrupt enable |
| upd_irq_en | input | 1 | Update-done interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| alarm_evt | input | 1 | One-cycle alarm-match event |
| update_evt | input | 1 | One-cycle update-done event |
| flag_rd | input | 1 | Flag register read strobe (clear on read) |
| flag_rdata | output | 8 | Flag byte: summary, periodic, alarm, update, zeros |
| irq | output | 1 | Interrupt request, active high |
| sqw | output | 1 | Square-wave output |

## Verification
The bench builds the block with its default widths: a 15-bit prescaler and a 4-bit rate code. With these values the slowest tap, code 15 at 16384 ticks, is within reach in one run when the tick is driven every cycle. The fastest tap, code 1, toggles on every tick. A tick stretched to every third clock shows that the period counts ticks and not clocks. The hold codes, the exact release latency, and reads that coincide with events are each driven in their own directed scenario.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;
  // Flag byte bit positions (software decodes these)
  localparam int FLG_SUM = 7;
  localparam int FLG_PER = 6;
  localparam int FLG_ALM = 5;
  localparam int FLG_UPD = 4;

  // Divider codes 3'b110 and 3'b111 keep the prescaler in reset
  function automatic logic div_is_held(input logic [2:0] code);
    return code[2] & code[1];
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (hold) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R3 / R4: a held divider restarts from zero
  a_r3_prescaler_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));
endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap #(
  parameter int CNT_W = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             sq_en,
  output logic             per_evt,
  output logic             sqw
);
  logic [CNT_W-1:0] tap_mask;
  logic             tap_hit;
  logic             sq_park;

  // Code r uses the low r-1 prescaler bits: event when they are all ones
  always_comb begin
    for (int i = 0; i < CNT_W; i++) tap_mask[i] = (int'(rate_sel) > i + 1);
  end

  assign tap_hit = tick && !hold && (rate_sel != '0) && ((cnt & tap_mask) == tap_mask);
  assign sq_park = !sq_en || (rate_sel == '0) || hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_evt <= 1'b0;
      sqw     <= 1'b0;
    end else begin
      per_evt <= tap_hit;
      if (sq_park)      sqw <= 1'b0;
      else if (tap_hit) sqw <= ~sqw;
    end
  end

  a_r1_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0) |=> !per_evt);
  a_r3_hold_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !per_evt);
  a_r2_sqw_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!sq_en || rate_sel == '0) |=> !sqw);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       per_evt,
  input  logic       alarm_evt,
  input  logic       update_evt,
  input  logic       rd,
  input  logic [2:0] en,      // {periodic, alarm, update}
  output logic [7:0] rdata,
  output logic       irq
);
  import rtc_rate_pkg::*;

  logic [2:0] flags;          // {periodic, alarm, update}
  logic [2:0] set_vec;
  logic       summary;

  assign set_vec = {per_evt, alarm_evt, update_evt};

  // A read clears; events of the same cycle land after the clear
  always_ff @(posedge clk) begin
    if (!rst_n)  flags <= '0;
    else if (rd) flags <= set_vec;
    else         flags <= flags | set_vec;
  end

  assign summary = |(flags & en);
  assign irq     = summary;

  always_comb begin
    rdata          = '0;
    rdata[FLG_SUM] = summary;
    rdata[FLG_PER] = flags[2];
    rdata[FLG_ALM] = flags[1];
    rdata[FLG_UPD] = flags[0];
  end

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && set_vec == '0) |=> (flags == '0));
  a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_evt || update_evt) |=> (flags[1] || flags[0]));
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && flags[2]) |=> flags[2]);
endmodule

// File: rtl/rtc_rate_irq.sv
module rtc_rate_irq #(
  parameter int PRESC_W = 15,
  parameter int RATE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [2:0]        div_ctl,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              per_irq_en,
  input  logic              alm_irq_en,
  input  logic              upd_irq_en,
  input  logic              sqw_en,
  input  logic              alarm_evt,
  input  logic              update_evt,
  input  logic              flag_rd,
  output logic [7:0]        flag_rdata,
  output logic              irq,
  output logic              sqw
);
  logic               hold;
  logic [PRESC_W-1:0] presc;
  logic               per_evt;

  assign hold = rtc_rate_pkg::div_is_held(div_ctl);

  rtc_prescaler #(.CNT_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick(ref_tick), .cnt(presc)
  );

  rtc_rate_tap #(.CNT_W(PRESC_W), .SEL_W(RATE_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick(ref_tick), .cnt(presc),
    .rate_sel(rate_sel), .sq_en(sqw_en), .per_evt(per_evt), .sqw(sqw)
  );

  rtc_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .per_evt(per_evt), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .rd(flag_rd),
    .en({per_irq_en, alm_irq_en, upd_irq_en}),
    .rdata(flag_rdata), .irq(irq)
  );

  a_r7_irq_is_summary: assert property (@(posedge clk) disable iff (!rst_n)
    irq == flag_rdata[7]);
endmodule

// File: tb/rtc_rate_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_rate_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [2:0] div_ctl = 3'b010;
  logic [3:0] rate_sel = '0;
  logic       per_irq_en = 1'b0, alm_irq_en = 1'b0, upd_irq_en = 1'b0, sqw_en = 1'b0;
  logic       alarm_evt = 1'b0, update_evt = 1'b0, flag_rd = 1'b0;
  logic [7:0] flag_rdata;
  logic       irq, sqw;

  int vectors = 0;
  int fails = 0;
  int tick_every = 1;
  int tph = 0;

  always #2.5 clk = ~clk;

  rtc_rate_irq dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_ctl(div_ctl),
    .rate_sel(rate_sel), .per_irq_en(per_irq_en), .alm_irq_en(alm_irq_en),
    .upd_irq_en(upd_irq_en), .sqw_en(sqw_en), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .flag_rd(flag_rd), .flag_rdata(flag_rdata),
    .irq(irq), .sqw(sqw)
  );

  // reference tick: one pulse every tick_every clocks
  always @(negedge clk) begin
    tph = (tph + 1 >= tick_every) ? 0 : tph + 1;
    ref_tick = (tph == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle read; returns the byte seen during the strobe
  task automatic rd_flags(output logic [7:0] v);
    flag_rd = 1'b1;
    #0.5 v = flag_rdata;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  task automatic sqw_period(output int per);
    logic p;
    int c;
    p = sqw; c = 0;
    while (sqw === p && c < 70000) begin @(negedge clk); c++; end
    p = sqw; c = 0;
    while (sqw === p && c < 70000) begin @(negedge clk); c++; end
    per = c;
  endtask

  task automatic t_reset;
    chk("R6 reset flag byte", flag_rdata, 0);
    chk("R7 reset irq", irq, 0);
    chk("R2 reset sqw", sqw, 0);
  endtask

  task automatic t_rates;
    int per;
    div_ctl = 3'b010; sqw_en = 1'b1; tick_every = 1;
    foreach (rate_list[k]) begin
      rate_sel = rate_list[k];
      cyc(2);
      sqw_period(per);
      chk($sformatf("R1 R2 rate %0d half period", rate_list[k]), per, 1 << (rate_list[k] - 1));
    end
    tick_every = 3; rate_sel = 4'd2;
    cyc(10);
    sqw_period(per);
    chk("R1 gapped tick period", per, 6);
    tick_every = 1;
  endtask
  int rate_list[3] = '{1, 3, 15};

  task automatic t_code0_and_sqwe;
    logic [7:0] v;
    int moved;
    rate_sel = 4'd0; sqw_en = 1'b1;
    cyc(3);
    rd_flags(v);
    moved = 0;
    repeat (100) begin @(negedge clk); if (sqw) moved++; end
    chk("R2 code 0 sqw low", moved, 0);
    rd_flags(v);
    chk("R1 code 0 no periodic flag", v[6], 0);
    rate_sel = 4'd3; sqw_en = 1'b0;
    moved = 0;
    repeat (50) begin @(negedge clk); if (sqw) moved++; end
    chk("R2 sqw disabled low", moved, 0);
    rd_flags(v);
    chk("R6 periodic flag without enable", v, 8'h40);
    rate_sel = 4'd0; cyc(3); rd_flags(v);
  endtask

  task automatic t_hold;
    logic [7:0] v;
    int moved;
    foreach (hold_codes[k]) begin
      div_ctl = hold_codes[k]; rate_sel = 4'd1; sqw_en = 1'b1;
      cyc(2); rd_flags(v);
      moved = 0;
      repeat (50) begin @(negedge clk); if (sqw) moved++; end
      chk($sformatf("R3 hold %0b sqw low", hold_codes[k]), moved, 0);
      rd_flags(v);
      chk($sformatf("R3 hold %0b no flag", hold_codes[k]), v, 0);
    end
    // release with rate 3: first sqw rise after exactly 4 ticks
    rate_sel = 4'd3;
    cyc(2);
    div_ctl = 3'b010;
    cyc(3);
    chk("R4 no event before full period", sqw, 0);
    cyc(1);
    chk("R4 first event after full period", sqw, 1);
  endtask
  logic [2:0] hold_codes[2] = '{3'b110, 3'b111};

  task automatic t_divcodes;
    int per;
    sqw_en = 1'b1; rate_sel = 4'd2;
    div_ctl = 3'b000; cyc(4); sqw_period(per);
    chk("R5 code 000 period", per, 2);
    div_ctl = 3'b001; cyc(4); sqw_period(per);
    chk("R5 code 001 period", per, 2);
    rate_sel = 4'd0; div_ctl = 3'b010; sqw_en = 1'b0;
  endtask

  task automatic t_flags;
    logic [7:0] v;
    rate_sel = 4'd0; per_irq_en = 0; alm_irq_en = 0; upd_irq_en = 0;
    cyc(3); rd_flags(v);
    alarm_evt = 1'b1; @(negedge clk); alarm_evt = 1'b0;
    chk("R6 alarm flag without enable", flag_rdata, 8'h20);
    chk("R7 irq low when disabled", irq, 0);
    alm_irq_en = 1'b1; #0.5;
    chk("R7 summary on enable", flag_rdata, 8'hA0);
    chk("R7 irq on enable", irq, 1);
    @(negedge clk);
    rd_flags(v);
    chk("R8 read returns flags", v, 8'hA0);
    chk("R8 cleared after read", flag_rdata, 0);
    chk("R8 irq cleared after read", irq, 0);
    upd_irq_en = 1'b1;
    update_evt = 1'b1; @(negedge clk); update_evt = 1'b0;
    chk("R7 update summary", flag_rdata, 8'h90);
    rd_flags(v);
    // same-cycle read and event
    upd_irq_en = 1'b0; alm_irq_en = 1'b0;
    update_evt = 1'b1; flag_rd = 1'b1;
    #0.5 v = flag_rdata;
    @(negedge clk);
    update_evt = 1'b0; flag_rd = 1'b0;
    chk("R9 read sees prior flags", v, 0);
    chk("R9 event kept after clear", flag_rdata, 8'h10);
    rd_flags(v);
    per_irq_en = 1'b1; rate_sel = 4'd1;
    cyc(5);
    rate_sel = 4'd0;
    chk("R7 periodic irq", irq, 1);
    chk("R6 R7 periodic flag byte", flag_rdata, 8'hC0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_rates();
    t_code0_and_sqwe();
    t_hold();
    t_divcodes();
    t_flags();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    vectors++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule